// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block models the command front end of a byte-wide flash device with small uniform sectors. It samples active-low chip-enable, output-enable and write-enable strobes on the system clock, together with a 15-bit address bus and a byte-wide data bus. The data bus reaches the pads as separate input, output and output-enable signals. The block decodes three unlock-protected command sequences: program one byte, erase one 128-byte sector, and erase the whole array. It applies each of them to a small internal byte array.

After a command is accepted, the block stays busy for a parameterised number of clock cycles. During that time every write is dropped. A read during that time returns a status byte instead of array content: a polling bit that shows the complement of the top bit being written, and a bit that flips on each completed read. When the busy period ends, the pending change is committed and normal array reads resume.

Top module: `flash_cmd_seq`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0. A bus write cycle additionally needs `oe_n` to be 1.
- R2: The writes 5555h/AAh, 2AAAh/55h and 5555h/A0h, followed by one write of address and data, start a byte program. The block is busy from the first clock edge at which the fourth write's strobes are seen released.
- R3: The address of a write is sampled at the first edge where `ce_n` and `we_n` are both low, so it follows whichever of the two falls later. The data is sampled at the first edge where either strobe is high again.
- R4: A program can only clear bits: the stored byte becomes old AND new. The array index is the low 9 address bits.
- R5: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, followed by 20h at any address, erase the 128-byte sector selected by address bits [8:7] to FFh. Other sectors keep their content.
- R6: The same five-write prefix followed by 10h at 5555h sets every byte to FFh. A 10h written at any other address has no effect, and the sequencer returns to idle.
- R7: Every write that ends while the block is busy is ignored, including one that would advance an unlock sequence.
- R8: While busy, a read returns bit 7 as the complement of bit 7 of the byte being written (erase writes FFh, so bit 7 reads 0). Bit 6 starts at 0 when the operation begins and inverts after each completed read. Bits 5:0 read 0.
- R9: A write that does not match the next expected step of a sequence returns the sequencer to idle.
- R10: A program stays busy for PROG_CYCLES clock cycles, capped at 20 µs worth of cycles at CLK_MHZ. An erase stays busy for ERASE_CYCLES cycles. On the first cycle after that, reads return array data.
- R11: After reset every byte reads FFh, the sequencer is idle and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address |
| dq_i | input | 8 | Data bus input from the pad |
| dq_o | output | 8 | Data bus output to the pad |
| dq_oe | output | 1 | Pad output enable |

## Verification
The bench moves the address and data during a single write cycle, with chip-enable falling ahead of write-enable. A design that sampled data at the start of the cycle, or sampled the address at the first strobe fall, would store the wrong byte at the wrong place. It replays a full unlock preamble while a program is still running. A sequencer that kept listening during busy would then program the following unqualified write. The bench reads exactly on the last busy cycle and on the first idle cycle to catch an off-by-one busy length. It also checks that an erase clears only its own sector, that a chip-erase code sent to the wrong address leaves the array untouched, and that successive status reads alternate bit 6.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int BUS_AW       = 15;
    localparam int DQ_W         = 8;
    localparam int PROG_MAX_US  = 20;

    localparam logic [BUS_AW-1:0] UNLOCK_A1 = 15'h5555;
    localparam logic [BUS_AW-1:0] UNLOCK_A2 = 15'h2AAA;
    localparam logic [DQ_W-1:0]   KEY_1     = 8'hAA;
    localparam logic [DQ_W-1:0]   KEY_2     = 8'h55;
    localparam logic [DQ_W-1:0]   CMD_PROG  = 8'hA0;
    localparam logic [DQ_W-1:0]   CMD_ERASE = 8'h80;
    localparam logic [DQ_W-1:0]   CMD_SECT  = 8'h20;
    localparam logic [DQ_W-1:0]   CMD_CHIP  = 8'h10;

    typedef enum logic [2:0] {
        S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_PROG, OP_SECT, OP_CHIP
    } op_kind_e;

    function automatic int clamp_cycles(input int req, input int lim);
        int r;
        r = (req < 1) ? 1 : req;
        if (r > lim) r = lim;
        return r;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic bus_match(input logic [BUS_AW-1:0] a,
                                       input logic [DQ_W-1:0]   d,
                                       input logic [BUS_AW-1:0] ea,
                                       input logic [DQ_W-1:0]   ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcs_strobe.sv
module fcs_strobe
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DQ_W-1:0]   dq_i,
    output logic              wr_evt,
    output logic [BUS_AW-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic              rd_end
);

    logic wr_act, rd_act;
    logic wr_q, rd_q;
    logic [BUS_AW-1:0] addr_lat;

    assign wr_act = ~ce_n & ~we_n & oe_n;
    assign rd_act = ~ce_n & ~oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            addr_lat <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            // start of a write: both strobes now low for the first time
            if (wr_act && !wr_q) addr_lat <= addr;
        end
    end

    // end of a write: first edge with a strobe back high; data taken now
    assign wr_evt  = wr_q & ~wr_act;
    assign wr_addr = addr_lat;
    assign wr_data = dq_i;
    assign rd_end  = rd_q & ~rd_act;

endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
    import fcs_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              busy,
    output logic              launch,
    output op_kind_e          op_kind,
    output logic [DQ_W-1:0]   op_data,
    output logic [IDX_W-1:0]  op_idx,
    output seq_state_e        state
);

    seq_state_e nxt;
    logic       take;

    assign take = wr_evt & ~busy;

    always_comb begin
        nxt     = state;
        launch  = 1'b0;
        op_kind = OP_PROG;
        op_data = wr_data;
        op_idx  = wr_addr[IDX_W-1:0];
        if (take) begin
            nxt = S_IDLE;
            case (state)
                S_IDLE: if (bus_match(wr_addr, wr_data, UNLOCK_A1, KEY_1)) nxt = S_U1;
                S_U1:   if (bus_match(wr_addr, wr_data, UNLOCK_A2, KEY_2)) nxt = S_U2;
                S_U2: begin
                    if (bus_match(wr_addr, wr_data, UNLOCK_A1, CMD_PROG))  nxt = S_PGM;
                    if (bus_match(wr_addr, wr_data, UNLOCK_A1, CMD_ERASE)) nxt = S_E3;
                end
                S_PGM: begin
                    launch  = 1'b1;
                    op_kind = OP_PROG;
                end
                S_E3:   if (bus_match(wr_addr, wr_data, UNLOCK_A1, KEY_1)) nxt = S_E4;
                S_E4:   if (bus_match(wr_addr, wr_data, UNLOCK_A2, KEY_2)) nxt = S_E5;
                S_E5: begin
                    op_data = '1;
                    if (wr_data == CMD_SECT) begin
                        launch  = 1'b1;
                        op_kind = OP_SECT;
                    end else if (bus_match(wr_addr, wr_data, UNLOCK_A1, CMD_CHIP)) begin
                        launch  = 1'b1;
                        op_kind = OP_CHIP;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer
    import fcs_pkg::*;
#(
    parameter int IDX_W     = 9,
    parameter int CNT_W     = 12,
    parameter int PROG_LEN  = 1500,
    parameter int ERASE_LEN = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  op_kind_e         op_kind,
    input  logic [DQ_W-1:0]  op_data,
    input  logic [IDX_W-1:0] op_idx,
    output logic             busy,
    output logic             done,
    output op_kind_e         pend_kind,
    output logic [DQ_W-1:0]  pend_data,
    output logic [IDX_W-1:0] pend_idx
);

    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_LEN - 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_LEN - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            pend_kind <= OP_PROG;
            pend_data <= '1;
            pend_idx  <= '0;
        end else if (launch && !busy) begin
            busy      <= 1'b1;
            cnt       <= (op_kind == OP_PROG) ? PROG_LD : ERASE_LD;
            pend_kind <= op_kind;
            pend_data <= op_data;
            pend_idx  <= op_idx;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int BYTES      = 512,
    parameter int SECT_BYTES = 128,
    parameter int IDX_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply,
    input  op_kind_e         kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DQ_W-1:0]  rd_data
);

    localparam int SECT_SH = $clog2(SECT_BYTES);

    logic [DQ_W-1:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '1;
        end else if (apply) begin
            if (kind == OP_PROG) begin
                mem[wr_idx] <= mem[wr_idx] & wr_data;
            end else begin
                for (int i = 0; i < BYTES; i++) begin
                    if (kind == OP_CHIP ||
                        (IDX_W'(i) >> SECT_SH) == (wr_idx >> SECT_SH))
                        mem[i] <= '1;
                end
            end
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ARRAY_BYTES  = 512,
    parameter int SECT_BYTES   = 128,
    parameter int CLK_MHZ      = 100,
    parameter int PROG_CYCLES  = 1500,
    parameter int ERASE_CYCLES = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DQ_W-1:0]   dq_i,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe
);

    localparam int IDX_W     = $clog2(ARRAY_BYTES);
    localparam int PROG_LEN  = clamp_cycles(PROG_CYCLES, PROG_MAX_US * CLK_MHZ);
    localparam int ERASE_LEN = clamp_cycles(ERASE_CYCLES, ERASE_CYCLES + 1);
    localparam int LONGEST   = max_int(PROG_LEN, ERASE_LEN);
    localparam int CNT_W     = $clog2(LONGEST + 1);

    logic              wr_evt, rd_end;
    logic [BUS_AW-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;
    logic              launch, busy, done;
    op_kind_e          op_kind, pend_kind;
    logic [DQ_W-1:0]   op_data, pend_data, arr_rd;
    logic [IDX_W-1:0]  op_idx, pend_idx;
    seq_state_e        seq_state;
    logic              tog;

    fcs_strobe u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_i(dq_i), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_end(rd_end)
    );

    fcs_cmd_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .launch(launch), .op_kind(op_kind),
        .op_data(op_data), .op_idx(op_idx), .state(seq_state)
    );

    fcs_busy_timer #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .PROG_LEN(PROG_LEN), .ERASE_LEN(ERASE_LEN)
    ) u_timer (
        .clk(clk), .rst(rst), .launch(launch), .op_kind(op_kind),
        .op_data(op_data), .op_idx(op_idx), .busy(busy), .done(done),
        .pend_kind(pend_kind), .pend_data(pend_data), .pend_idx(pend_idx)
    );

    fcs_array #(
        .BYTES(ARRAY_BYTES), .SECT_BYTES(SECT_BYTES), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk), .rst(rst), .apply(done), .kind(pend_kind),
        .wr_idx(pend_idx), .wr_data(pend_data),
        .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_rd)
    );

    // status toggle: cleared when an operation starts, flips per finished read
    always_ff @(posedge clk) begin
        if (rst)                 tog <= 1'b0;
        else if (launch)         tog <= 1'b0;
        else if (busy && rd_end) tog <= ~tog;
    end

    assign dq_oe = ~ce_n & ~oe_n;
    assign dq_o  = busy ? {~pend_data[DQ_W-1], tog, {(DQ_W-2){1'b0}}} : arr_rd;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int LIMIT = 3000
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              launch,
    input logic              done,
    input logic              wr_evt,
    input logic [BUS_AW-1:0] wr_addr,
    input logic [DQ_W-1:0]   wr_data,
    input logic              rd_end,
    input seq_state_e        seq_state,
    input logic [DQ_W-1:0]   dq_o
);

    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy); // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < 32'(LIMIT))); // R10
    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_end && !done) |=> (dq_o[6] != $past(dq_o[6]))); // R8
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_evt) |=> (seq_state == $past(seq_state))); // R7
    AST_SEQ_ABORT: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_evt && seq_state == S_U1 &&
         !(wr_addr == UNLOCK_A2 && wr_data == KEY_2)) |=> (seq_state == S_IDLE)); // R9

endmodule

bind flash_cmd_seq fcs_checker #(.LIMIT(LONGEST)) u_fcs_checker (
    .clk(clk), .rst(rst), .busy(busy), .launch(launch), .done(done),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data), .rd_end(rd_end),
    .seq_state(seq_state), .dq_o(dq_o)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int PN = 12;
    localparam int EN = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  dq_i = '0;
    logic [7:0]  dq_o;
    logic        dq_oe;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] shadow [512];

    always #5 clk = ~clk;

    flash_cmd_seq #(
        .ARRAY_BYTES(512), .SECT_BYTES(128), .CLK_MHZ(100),
        .PROG_CYCLES(PN), .ERASE_CYCLES(EN)
    ) u_flash_cmd_seq (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // program vectors: {address, data}; expected value comes from the shadow
    localparam logic [22:0] PVEC [6] = '{
        {15'h0010, 8'h5A}, {15'h0010, 8'hF0}, {15'h0155, 8'h00},
        {15'h01FF, 8'hA5}, {15'h0080, 8'h3C}, {15'h0080, 8'hC3}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 v = dq_o;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic pgm(input logic [14:0] a, input logic [7:0] d);
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAA, 8'h55);
        bus_wr(15'h5555, 8'hA0); bus_wr(a, d);
        shadow[a[8:0]] = shadow[a[8:0]] & d;
    endtask

    task automatic erase_pre();
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAA, 8'h55);
        bus_wr(15'h5555, 8'h80); bus_wr(15'h5555, 8'hAA);
        bus_wr(15'h2AAA, 8'h55);
    endtask

    task automatic expect_rd(input string tag, input logic [14:0] a);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, shadow[a[8:0]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 512; i++) shadow[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11 reset state, R1 bus drive
        expect_rd("R11 reset byte 000", 15'h0000);
        expect_rd("R11 reset byte 1FF", 15'h01FF);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1 chk("R1 ce high", {7'b0, dq_oe}, 8'h00);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1 chk("R1 oe high", {7'b0, dq_oe}, 8'h00);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; #1 chk("R1 both low", {7'b0, dq_oe}, 8'h01);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;

        // R2 / R4 vector walk
        for (int k = 0; k < 6; k++) begin
            pgm(PVEC[k][22:8], PVEC[k][7:0]);
            repeat (PN) @(negedge clk);
            expect_rd("R2 R4 program vector", PVEC[k][22:8]);
        end

        // R8 status byte and toggle during a program
        pgm(15'h0040, 8'h12);
        rd(15'h0040, v); chk("R8 status read 1", v, 8'h80);
        rd(15'h0040, v); chk("R8 status read 2", v, 8'hC0);
        rd(15'h0040, v); chk("R8 status read 3", v, 8'h80);
        repeat (PN) @(negedge clk);
        expect_rd("R8 data after busy", 15'h0040);

        // R10 boundary: last busy cycle, then first idle cycle
        pgm(15'h0041, 8'h00);
        repeat (PN - 1) @(negedge clk);
        rd(15'h0041, v); chk("R10 last busy cycle", v, 8'h80);
        expect_rd("R10 after busy", 15'h0041);
        pgm(15'h0042, 8'h0F);
        repeat (PN) @(negedge clk);
        expect_rd("R10 first idle cycle", 15'h0042);

        // R3 skewed strobes, address and data moving inside the cycle
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAA, 8'h55); bus_wr(15'h5555, 8'hA0);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = 15'h0050; dq_i = 8'h00;
        @(negedge clk); we_n = 1'b0; addr = 15'h0060; dq_i = 8'h00;
        @(negedge clk); addr = 15'h0070; dq_i = 8'h33;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        shadow[9'h060] = 8'h33;
        repeat (PN) @(negedge clk);
        expect_rd("R3 latched address", 15'h0060);
        expect_rd("R3 early address untouched", 15'h0050);
        expect_rd("R3 late address untouched", 15'h0070);

        // R7 preamble during busy must be dropped
        pgm(15'h00A0, 8'h0F);
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAA, 8'h55); bus_wr(15'h5555, 8'hA0);
        repeat (PN) @(negedge clk);
        bus_wr(15'h00A1, 8'h00);
        repeat (PN) @(negedge clk);
        expect_rd("R7 ignored preamble", 15'h00A1);
        expect_rd("R7 program intact", 15'h00A0);

        // R9 mismatches return to idle
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAB, 8'h55); bus_wr(15'h5555, 8'hA0);
        bus_wr(15'h0090, 8'h00);
        repeat (PN) @(negedge clk);
        expect_rd("R9 bad second address", 15'h0090);
        bus_wr(15'h5555, 8'hAA); bus_wr(15'h2AAA, 8'h55); bus_wr(15'h5555, 8'h77);
        bus_wr(15'h0091, 8'h00);
        repeat (PN) @(negedge clk);
        expect_rd("R9 unknown command", 15'h0091);

        // R5 sector erase of sector 2 (0x100..0x17F)
        pgm(15'h0100, 8'h11); repeat (PN) @(negedge clk);
        pgm(15'h017F, 8'h22); repeat (PN) @(negedge clk);
        pgm(15'h00FF, 8'h44); repeat (PN) @(negedge clk);
        pgm(15'h0180, 8'h44); repeat (PN) @(negedge clk);
        erase_pre(); bus_wr(15'h0123, 8'h20);
        for (int i = 256; i < 384; i++) shadow[i] = 8'hFF;
        rd(15'h0100, v); chk("R8 R5 erase status", v, 8'h00);
        repeat (EN) @(negedge clk);
        expect_rd("R5 sector start erased", 15'h0100);
        expect_rd("R5 sector end erased", 15'h017F);
        expect_rd("R5 lower neighbour kept", 15'h00FF);
        expect_rd("R5 upper neighbour kept", 15'h0180);

        // R6 chip erase: wrong address first, then correct
        erase_pre(); bus_wr(15'h0001, 8'h10);
        repeat (EN) @(negedge clk);
        expect_rd("R6 wrong address no erase", 15'h0180);
        erase_pre(); bus_wr(15'h5555, 8'h10);
        for (int i = 0; i < 512; i++) shadow[i] = 8'hFF;
        repeat (EN) @(negedge clk);
        expect_rd("R6 chip erase 010", 15'h0010);
        expect_rd("R6 chip erase 180", 15'h0180);
        expect_rd("R6 chip erase 0FF", 15'h00FF);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule